// File: doc/BRIEF.md
# Per-Half-Bridge Overcurrent Limiter

This block sits between a PWM modulator and the gate drivers of one half-bridge. Each PWM frame it passes the requested level through to complementary high-side and low-side drive commands. When the current comparator trips during a frame, it flips the output to the opposite state for the rest of that frame. It then hands the level back to the modulator at the next frame start.

A saturating up/down counter measures how long the overload lasts. It steps up once for each frame in which the comparator tripped and steps down once for each clean frame. When it reaches its span, the channel is parked with both switches off until reset. In latched mode the first trip parks the channel at once. A frame is treated as saturated when the previous frame either held a trip or had a request that never changed. A saturated frame raises a clip flag. On every fourth frame start while saturated, a narrow pulse of inverted drive is inserted so that the stage keeps switching at one quarter of the frame rate.

All pins are plain control and status levels. No data stream is carried, so there is no valid/ready handshake and no back-pressure.

Top module: `oc_limiter`

## Requirements
- R1: After reset the channel is not shut down, the clip flag is 0, the frame index is 0, the overload count is 0, and the drive follows the request: `hs_on` = `pwm_req`, `ls_on` = not `pwm_req`.
- R2: With no trip and no saturation, `hs_on` equals `pwm_req` and `ls_on` is its complement in the same cycle. The two are never both 1.
- R3: A trip on `oc_flag` in a cycle without `frame_start` inverts the drive from the next cycle on (`hs_on` = not `pwm_req`). The inversion holds until the clock edge on which `frame_start` is seen.
- R4: When `oc_flag` and `frame_start` are high in the same cycle, the trip belongs to the new frame. The drive is inverted from the next cycle for that whole new frame, and the finished frame is judged only on its own earlier trips.
- R5: At each `frame_start`, the overload count rises by 1 if the frame just finished held a trip, and otherwise falls by 1. The count never goes below 0, so clean frames at zero have no effect on later shutdown timing.
- R6: When a rise would bring the count to `OVL_FRAMES`, `shutdown` goes to 1 on that edge. While `shutdown` is 1, `hs_on` and `ls_on` are both 0. It stays 1 until reset.
- R7: With `latch_mode` = 1, any trip sets `shutdown` on the next clock edge, whatever the count.
- R8: At each `frame_start`, `clip_active` becomes 1 if the finished frame held a trip or `pwm_req` never changed during it. It becomes 0 if the frame held neither. A change counts toward the frame in whose cycle the new level is first seen.
- R9: A frame counter modulo 4 steps at every `frame_start`. When it wraps to 0 and the new frame is saturated, the drive is inverted for `PULSE_W` cycles starting the cycle after that `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | One-cycle strobe opening a PWM frame |
| pwm_req | input | 1 | Requested switch state, 1 = high side on |
| oc_flag | input | 1 | Overcurrent comparator output, 1 = tripped |
| latch_mode | input | 1 | 1 = shut down on first trip, 0 = limit per frame |
| hs_on | output | 1 | High-side drive command |
| ls_on | output | 1 | Low-side drive command |
| shutdown | output | 1 | Channel parked with both switches off |
| clip_active | output | 1 | Current frame is saturated |

## Verification
Two collisions matter most. The first is a trip arriving on the very cycle of a frame start, which must both open the new frame's inversion and stay out of the previous frame's overload verdict. The second is an injection frame landing while the output is already flipped, where the narrow pulse inverts the flipped level. The bench forces the first with directed frames that place `oc_flag` on the strobe cycle. The second comes from held requests combined with random trip positions. Both are judged cycle by cycle against a reference model built from the requirements. Directed counts of shutdown timing and of injected low cycles back up that model.

// File: rtl/oc_limiter_pkg.sv
package oc_limiter_pkg;
  typedef struct packed {
    logic hs;
    logic ls;
  } drive_t;

  localparam drive_t DRIVE_OFF = '{hs: 1'b0, ls: 1'b0};
endpackage

// File: rtl/ocl_frame_track.sv
module ocl_frame_track #(
  parameter int PULSE_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic pwm_req,
  input  logic oc_flag,
  output logic prev_oc,
  output logic sat_q,
  output logic inj_active
);
  localparam int IW = $clog2(PULSE_W + 1);

  logic          foc_q, tog_q, prev_req_q;
  logic [1:0]    fidx_q;
  logic [IW-1:0] inj_q;
  logic          tog_now, sat_n;
  logic [1:0]    fidx_n;

  assign tog_now = (pwm_req != prev_req_q);
  assign sat_n   = foc_q | ~tog_q;
  assign fidx_n  = fidx_q + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foc_q      <= 1'b0;
      tog_q      <= 1'b1;
      prev_req_q <= 1'b0;
      fidx_q     <= 2'd0;
      sat_q      <= 1'b0;
      inj_q      <= '0;
    end else begin
      prev_req_q <= pwm_req;
      if (frame_start) begin
        foc_q  <= oc_flag;
        tog_q  <= tog_now;
        sat_q  <= sat_n;
        fidx_q <= fidx_n;
        inj_q  <= (fidx_n == 2'd0 && sat_n) ? IW'(PULSE_W) : '0;
      end else begin
        foc_q <= foc_q | oc_flag;
        tog_q <= tog_q | tog_now;
        if (inj_q != '0) inj_q <= inj_q - IW'(1);
      end
    end
  end

  assign prev_oc    = foc_q;
  assign inj_active = (inj_q != '0);

  a_r9_inj_only_sat: assert property (@(posedge clk) disable iff (!rst_n)
    inj_active |-> sat_q);
  a_r8_clip_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_q) |-> $past(frame_start));
endmodule

// File: rtl/ocl_overload_ctr.sv
module ocl_overload_ctr #(
  parameter int OVL_FRAMES = 1035
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic prev_oc,
  input  logic latch_mode,
  input  logic oc_flag,
  output logic shutdown
);
  localparam int CW = $clog2(OVL_FRAMES + 1);
  localparam logic [CW-1:0] TOP  = CW'(OVL_FRAMES);
  localparam logic [CW-1:0] TRIP = CW'(OVL_FRAMES - 1);

  logic [CW-1:0] cnt_q;
  logic          shut_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      shut_q <= 1'b0;
    end else begin
      if (frame_start) begin
        if (prev_oc) begin
          if (cnt_q != TOP) cnt_q <= cnt_q + CW'(1);
          if (cnt_q == TRIP) shut_q <= 1'b1;
        end else if (cnt_q != '0) begin
          cnt_q <= cnt_q - CW'(1);
        end
      end
      if (latch_mode && oc_flag) shut_q <= 1'b1;
    end
  end

  assign shutdown = shut_q;

  a_r5_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !prev_oc && cnt_q == '0) |=> (cnt_q == '0));
  a_r5_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP);
endmodule

// File: rtl/ocl_gate.sv
module ocl_gate
  import oc_limiter_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   frame_start,
  input  logic   oc_flag,
  input  logic   pwm_req,
  input  logic   inj_active,
  input  logic   shutdown,
  output drive_t drv
);
  logic flip_q;
  logic lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           flip_q <= 1'b0;
    else if (frame_start) flip_q <= oc_flag;
    else if (oc_flag)     flip_q <= 1'b1;
  end

  assign lvl = pwm_req ^ flip_q ^ inj_active;

  always_comb begin
    if (shutdown) drv = DRIVE_OFF;
    else          drv = '{hs: lvl, ls: ~lvl};
  end

  a_r3_flip_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (flip_q && !frame_start) |=> flip_q);
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv.hs && drv.ls));
endmodule

// File: rtl/oc_limiter.sv
module oc_limiter
  import oc_limiter_pkg::*;
#(
  parameter int OVL_FRAMES = 1035,
  parameter int PULSE_W    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic pwm_req,
  input  logic oc_flag,
  input  logic latch_mode,
  output logic hs_on,
  output logic ls_on,
  output logic shutdown,
  output logic clip_active
);
  logic   prev_oc, sat_q, inj_active, shut;
  drive_t drv;

  ocl_frame_track #(.PULSE_W(PULSE_W)) u_track (
    .clk, .rst_n, .frame_start, .pwm_req, .oc_flag,
    .prev_oc(prev_oc), .sat_q(sat_q), .inj_active(inj_active)
  );

  ocl_overload_ctr #(.OVL_FRAMES(OVL_FRAMES)) u_ctr (
    .clk, .rst_n, .frame_start, .prev_oc(prev_oc),
    .latch_mode, .oc_flag, .shutdown(shut)
  );

  ocl_gate u_gate (
    .clk, .rst_n, .frame_start, .oc_flag, .pwm_req,
    .inj_active(inj_active), .shutdown(shut), .drv(drv)
  );

  assign hs_on       = drv.hs;
  assign ls_on       = drv.ls;
  assign shutdown    = shut;
  assign clip_active = sat_q;

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> shutdown);
  a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> (!hs_on && !ls_on));
  a_r7_latch_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_mode && oc_flag) |=> shutdown);
endmodule

// File: tb/tb_oc_limiter.sv
module tb_oc_limiter;
  localparam int OVL = 6;
  localparam int PW  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0, pwm_req = 1'b0, oc_flag = 1'b0, latch_mode = 1'b0;
  logic hs_on, ls_on, shutdown, clip_active;

  oc_limiter #(.OVL_FRAMES(OVL), .PULSE_W(PW)) dut (
    .clk, .rst_n, .frame_start, .pwm_req, .oc_flag, .latch_mode,
    .hs_on, .ls_on, .shutdown, .clip_active
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0, lowcnt = 0;
  bit done = 0;

  // reference model state
  bit m_flip, m_foc, m_tog, m_prev, m_sat, m_shut;
  int m_fidx, m_inj, m_cnt;

  task automatic model_reset();
    m_flip = 0; m_foc = 0; m_tog = 1; m_prev = 0; m_sat = 0; m_shut = 0;
    m_fidx = 0; m_inj = 0; m_cnt = 0;
  endtask

  function automatic logic [3:0] expect_out(bit pwm);
    bit d;
    d = pwm ^ m_flip ^ (m_inj != 0);
    if (m_shut) return {2'b00, 1'b1, m_sat};
    return {d, ~d, 1'b0, m_sat};
  endfunction

  task automatic model_step(bit fs, bit pwm, bit oc, bit lm);
    bit tnow, nsat;
    int nf;
    tnow = (pwm != m_prev);
    if (fs) begin
      nsat = m_foc | !m_tog;
      nf = (m_fidx + 1) % 4;
      if (m_foc) begin
        if (m_cnt != OVL) m_cnt++;
        if (m_cnt == OVL) m_shut = 1;
      end else if (m_cnt > 0) m_cnt--;
      m_inj = (nf == 0 && nsat) ? PW : 0;
      m_foc = oc; m_tog = tnow; m_flip = oc; m_sat = nsat; m_fidx = nf;
    end else begin
      m_foc |= oc; m_tog |= tnow; m_flip |= oc;
      if (m_inj > 0) m_inj--;
    end
    m_prev = pwm;
    if (lm && oc) m_shut = 1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(bit fs, bit pwm, bit oc, bit lm, string tag);
    @(negedge clk);
    frame_start = fs; pwm_req = pwm; oc_flag = oc; latch_mode = lm;
    #1;
    chk(tag, {28'd0, hs_on, ls_on, shutdown, clip_active}, {28'd0, expect_out(pwm)});
    if (!hs_on && !shutdown) lowcnt++;
    @(posedge clk);
    model_step(fs, pwm, oc, lm);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; frame_start = 0; pwm_req = 0; oc_flag = 0; latch_mode = 0;
    repeat (2) @(posedge clk);
    model_reset();
    @(negedge clk);
    rst_n = 1;
  endtask

  // one frame: hold keeps pwm at 1, else high first half; oc_at < 0 means none
  task automatic frame(int len, bit hold, int oc_at, bit lm, string tag);
    for (int i = 0; i < len; i++)
      tick(i == 0, hold ? 1'b1 : (i < len / 2), i == oc_at, lm, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    model_reset();
    do_reset();
    // R1 reset state
    #1;
    chk("R1 reset", {28'd0, hs_on, ls_on, shutdown, clip_active}, 32'h4);
    // R2 normal toggling frames
    for (int f = 0; f < 6; f++) frame(8, 0, -1, 0, "R2");
    // R3 trip mid-frame
    frame(8, 0, 2, 0, "R3");
    frame(8, 0, -1, 0, "R3");
    // R4 trip on strobe cycle
    frame(8, 0, 0, 0, "R4");
    frame(8, 0, -1, 0, "R4");
    // R5 floor: clean frames then trips
    do_reset();
    for (int f = 0; f < 10; f++) frame(6, 0, -1, 0, "R5");
    for (int f = 0; f < 6; f++) frame(6, 0, 3, 0, "R5");
    chk("R5 not yet tripped", {31'd0, shutdown}, 32'd0);
    tick(1, 1, 0, 0, "R5");
    #2;
    chk("R5 trip after floor", {31'd0, shutdown}, 32'd1);
    // R5 alternation never trips
    do_reset();
    for (int f = 0; f < 20; f++) frame(6, 0, (f % 2 == 0) ? 2 : -1, 0, "R5");
    chk("R5 alternating", {31'd0, shutdown}, 32'd0);
    // R6 sticky shutdown
    do_reset();
    for (int f = 0; f < 7; f++) frame(6, 0, 1, 0, "R6");
    for (int f = 0; f < 4; f++) frame(6, 0, -1, 0, "R6");
    chk("R6 sticky", {29'd0, hs_on, ls_on, shutdown}, 32'd1);
    // R7 latched mode
    do_reset();
    frame(6, 0, -1, 1, "R7");
    tick(1, 1, 0, 1, "R7");
    tick(0, 1, 1, 1, "R7");
    #2;
    chk("R7 latched", {31'd0, shutdown}, 32'd1);
    // R8/R9 held request: clip and injection
    do_reset();
    lowcnt = 0;
    for (int f = 0; f < 8; f++) frame(8, 1, -1, 0, "R9");
    chk("R9 injected low cycles", lowcnt, 2 * PW);
    chk("R8 clip while held", {31'd0, clip_active}, 32'd1);
    frame(8, 0, -1, 0, "R8");
    tick(1, 1, 0, 0, "R8");
    #2;
    chk("R8 clip clears", {31'd0, clip_active}, 32'd0);
    // random mix
    for (int f = 0; f < 400; f++) begin
      int len, ocp;
      bit hold;
      if (f % 60 == 0) do_reset();
      len  = 5 + ($urandom % 8);
      hold = ($urandom % 4) == 0;
      ocp  = (($urandom % 6) == 0) ? int'($urandom % len) : -1;
      frame(len, hold, ocp, 0, "R2 random");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule